// File: doc/BRIEF.md
# Trap Status and Interrupt Register Bank

This block holds the machine-level status, interrupt-enable, interrupt-pending, delegation and trap-vector registers of a processor hart. It also presents the narrower supervisor views of the shared status, enable and pending registers. An access front end has already resolved the read-modify-write operation. It presents a 12-bit register address, a write strobe and the fully merged write data. The bank returns the current contents of the addressed register in the same cycle, and any write lands at the next clock edge.

Every write passes through a per-register writable mask and a legality filter. The supervisor registers hold no storage of their own. They are masked windows onto the machine registers, and the interrupt-delegation register gates the enable and pending windows. The status summary-dirty bit is computed from the floating-point and extension state fields on every read and is not stored. Three hardware interrupt lines drive their pending positions every cycle: machine timer, machine external and supervisor external. Software cannot write those positions.

Top module: `trap_csr_bank`

## Requirements
- R1: After reset every register reads 0, except address 0xF14, which reads the HART_ID parameter. Addresses 0xF11, 0xF12 and 0xF13 always read 0, as does any unmapped address. Writes to these addresses have no effect.
- R2: Machine status (0x300) accepts writes only in bits 1, 3, 5, 7, 8, 11–14 and 17–22, which is mask 0x007E79AA. Every other bit keeps its value.
- R3: Status bit 31 reads 1 exactly when bits 14:13 equal 3 or bits 16:15 equal 3. It reads 0 otherwise and is never stored.
- R4: Supervisor status (0x100) reads machine status AND 0x800DE133. A write there changes only the bits in both that mask and the machine writable mask.
- R5: Machine interrupt enable (0x304) accepts writes only in bits 1, 3, 5, 7, 9 and 11 (0xAAA). Interrupt delegation (0x303) accepts writes only in bits 1, 5 and 9 (0x222).
- R6: Supervisor interrupt enable (0x104) reads machine enable AND delegation. A write changes only the machine enable bits that are delegated.
- R7: Exception delegation (0x302) accepts writes only for causes 0–9, 12, 13 and 15 (0xB3FF). Causes 10 and 14 always read 0.
- R8: A write to machine trap vector (0x305) or supervisor trap vector (0x105) whose bits 1:0 are 2 or 3 is dropped and the old value is kept. Modes 0 and 1 are stored in full.
- R9: A write to machine pending (0x344) changes only bits 1 and 5. A write to supervisor pending (0x144) changes only bit 1, and only while delegation bit 1 is set. Supervisor pending reads machine pending AND delegation.
- R10: Pending bit 7 follows irqTimerIn, bit 11 follows irqExtIn and bit 9 follows irqSupExtIn, each one clock after the input. Software writes to these bits have no effect.
- R11: rdData shows the addressed register combinationally. During a write cycle it shows the value before the write, and the new value appears after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the addressed register |
| addr | input | 12 | Register address |
| wrData | input | XLEN | Merged write data |
| irqTimerIn | input | 1 | Machine timer interrupt request |
| irqExtIn | input | 1 | Machine external interrupt request |
| irqSupExtIn | input | 1 | Supervisor external interrupt request |
| rdData | output | XLEN | Read data for the addressed register |

## Verification
Every register is observable through rdData, so a corrupted storage bit or a leaking writable mask shows up on the first read of the affected address. It also shows up on the aliased supervisor address, because both views share one storage. A bad delegation bit shows at once in three places: the supervisor enable view, the supervisor pending view and the legality of a later supervisor pending write. A fault on a hardware interrupt path shows one cycle after the input changes, as a pending bit that fails to follow it. A fault in the trap-vector filter shows on the read that follows a dropped write.

// File: rtl/trap_csr_pkg.sv
package trap_csr_pkg;

  localparam logic [11:0] ADDR_SSTATUS = 12'h100;
  localparam logic [11:0] ADDR_SIE     = 12'h104;
  localparam logic [11:0] ADDR_STVEC   = 12'h105;
  localparam logic [11:0] ADDR_SIP     = 12'h144;
  localparam logic [11:0] ADDR_MSTATUS = 12'h300;
  localparam logic [11:0] ADDR_MEDELEG = 12'h302;
  localparam logic [11:0] ADDR_MIDELEG = 12'h303;
  localparam logic [11:0] ADDR_MIE     = 12'h304;
  localparam logic [11:0] ADDR_MTVEC   = 12'h305;
  localparam logic [11:0] ADDR_MIP     = 12'h344;
  localparam logic [11:0] ADDR_VENDOR  = 12'hF11;
  localparam logic [11:0] ADDR_ARCH    = 12'hF12;
  localparam logic [11:0] ADDR_IMPL    = 12'hF13;
  localparam logic [11:0] ADDR_HART    = 12'hF14;

  // Base masks in the low 32 bits; the summary bit position is added per XLEN.
  localparam logic [31:0] STATUS_WR_MASK  = 32'h007E_79AA;
  localparam logic [31:0] SSTATUS_VIEW_LO = 32'h000D_E133;
  localparam logic [31:0] IRQ_ENABLE_MASK = 32'h0000_0AAA;
  localparam logic [31:0] IRQ_DELEG_MASK  = 32'h0000_0222;
  localparam logic [31:0] EXC_DELEG_MASK  = 32'h0000_B3FF;
  localparam logic [31:0] SUP_SW_PEND     = 32'h0000_0002;

  localparam int TIMER_BIT   = 7;
  localparam int EXT_BIT     = 11;
  localparam int SUP_EXT_BIT = 9;

  typedef enum logic [3:0] {
    SEL_ZERO, SEL_MSTATUS, SEL_SSTATUS, SEL_MIE, SEL_SIE, SEL_MIDELEG,
    SEL_MEDELEG, SEL_MTVEC, SEL_STVEC, SEL_MIP, SEL_SIP, SEL_HART
  } rdSel_e;

  typedef struct packed {
    logic   wrMstatus;
    logic   wrSstatus;
    logic   wrMie;
    logic   wrSie;
    logic   wrMideleg;
    logic   wrMedeleg;
    logic   wrMtvec;
    logic   wrStvec;
    logic   wrMip;
    logic   wrSip;
    rdSel_e rdSel;
  } csrCtl_t;

endpackage

// File: rtl/trap_csr_ctrl.sv
module trap_csr_ctrl
  import trap_csr_pkg::*;
(
  input  logic        wrEn,
  input  logic [11:0] addr,
  output csrCtl_t     ctl
);

  always_comb begin
    ctl = '0;
    ctl.rdSel = SEL_ZERO;
    case (addr)
      ADDR_MSTATUS: begin ctl.rdSel = SEL_MSTATUS; ctl.wrMstatus = wrEn; end
      ADDR_SSTATUS: begin ctl.rdSel = SEL_SSTATUS; ctl.wrSstatus = wrEn; end
      ADDR_MIE:     begin ctl.rdSel = SEL_MIE;     ctl.wrMie     = wrEn; end
      ADDR_SIE:     begin ctl.rdSel = SEL_SIE;     ctl.wrSie     = wrEn; end
      ADDR_MIDELEG: begin ctl.rdSel = SEL_MIDELEG; ctl.wrMideleg = wrEn; end
      ADDR_MEDELEG: begin ctl.rdSel = SEL_MEDELEG; ctl.wrMedeleg = wrEn; end
      ADDR_MTVEC:   begin ctl.rdSel = SEL_MTVEC;   ctl.wrMtvec   = wrEn; end
      ADDR_STVEC:   begin ctl.rdSel = SEL_STVEC;   ctl.wrStvec   = wrEn; end
      ADDR_MIP:     begin ctl.rdSel = SEL_MIP;     ctl.wrMip     = wrEn; end
      ADDR_SIP:     begin ctl.rdSel = SEL_SIP;     ctl.wrSip     = wrEn; end
      ADDR_HART:    ctl.rdSel = SEL_HART;
      default:      ctl.rdSel = SEL_ZERO;
    endcase
  end

endmodule

// File: rtl/trap_csr_dp.sv
module trap_csr_dp
  import trap_csr_pkg::*;
#(
  parameter int          XLEN    = 32,
  parameter logic [31:0] HART_ID = 32'h0
) (
  input  logic            clk,
  input  logic            rstN,
  input  csrCtl_t         ctl,
  input  logic [XLEN-1:0] wrData,
  input  logic            irqTimerIn,
  input  logic            irqExtIn,
  input  logic            irqSupExtIn,
  output logic [XLEN-1:0] rdData
);

  localparam logic [XLEN-1:0] SD_BIT     = XLEN'(1) << (XLEN-1);
  localparam logic [XLEN-1:0] M_ST_MASK  = XLEN'(STATUS_WR_MASK);
  localparam logic [XLEN-1:0] S_ST_VIEW  = XLEN'(SSTATUS_VIEW_LO) | SD_BIT;
  localparam logic [XLEN-1:0] IE_MASK    = XLEN'(IRQ_ENABLE_MASK);
  localparam logic [XLEN-1:0] IDEL_MASK  = XLEN'(IRQ_DELEG_MASK);
  localparam logic [XLEN-1:0] EDEL_MASK  = XLEN'(EXC_DELEG_MASK);
  localparam logic [XLEN-1:0] HW_CLAIM   = XLEN'(1) << SUP_EXT_BIT;
  localparam logic [XLEN-1:0] M_SW_PEND  = IDEL_MASK & ~HW_CLAIM;
  localparam logic [XLEN-1:0] S_SW_PEND  = XLEN'(SUP_SW_PEND);

  logic [XLEN-1:0] mstatusQ, mieQ, midelegQ, medelegQ, mtvecQ, stvecQ, mipSwQ;
  logic            hwTimerQ, hwExtQ, hwSupExtQ;

  logic [XLEN-1:0] statusSrc, enableSrc, pendWrMask;
  logic [XLEN-1:0] mstatusView, mipView;
  logic            dirty;

  // Supervisor writes are first merged into the machine image, then share the machine path
  assign statusSrc = ctl.wrSstatus ? ((mstatusQ & ~S_ST_VIEW) | (wrData & S_ST_VIEW)) : wrData;
  assign enableSrc = ctl.wrSie ? ((mieQ & ~midelegQ) | (wrData & midelegQ)) : wrData;

  always_comb begin
    pendWrMask = '0;
    if (ctl.wrMip)      pendWrMask = M_SW_PEND;
    else if (ctl.wrSip) pendWrMask = M_SW_PEND & S_SW_PEND & midelegQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mstatusQ  <= '0;
      mieQ      <= '0;
      midelegQ  <= '0;
      medelegQ  <= '0;
      mtvecQ    <= '0;
      stvecQ    <= '0;
      mipSwQ    <= '0;
      hwTimerQ  <= 1'b0;
      hwExtQ    <= 1'b0;
      hwSupExtQ <= 1'b0;
    end else begin
      if (ctl.wrMstatus || ctl.wrSstatus)
        mstatusQ <= (mstatusQ & ~M_ST_MASK) | (statusSrc & M_ST_MASK);
      if (ctl.wrMie || ctl.wrSie)
        mieQ <= (mieQ & ~IE_MASK) | (enableSrc & IE_MASK);
      if (ctl.wrMideleg)
        midelegQ <= (midelegQ & ~IDEL_MASK) | (wrData & IDEL_MASK);
      if (ctl.wrMedeleg)
        medelegQ <= (medelegQ & ~EDEL_MASK) | (wrData & EDEL_MASK);
      if (ctl.wrMtvec && !wrData[1])
        mtvecQ <= wrData;
      if (ctl.wrStvec && !wrData[1])
        stvecQ <= wrData;
      mipSwQ    <= (mipSwQ & ~pendWrMask) | (wrData & pendWrMask);
      hwTimerQ  <= irqTimerIn;
      hwExtQ    <= irqExtIn;
      hwSupExtQ <= irqSupExtIn;
    end
  end

  assign dirty       = (mstatusQ[14:13] == 2'b11) || (mstatusQ[16:15] == 2'b11);
  assign mstatusView = mstatusQ | (dirty ? SD_BIT : '0);
  assign mipView     = mipSwQ
                     | (XLEN'(hwTimerQ)  << TIMER_BIT)
                     | (XLEN'(hwExtQ)    << EXT_BIT)
                     | (XLEN'(hwSupExtQ) << SUP_EXT_BIT);

  always_comb begin
    case (ctl.rdSel)
      SEL_MSTATUS: rdData = mstatusView;
      SEL_SSTATUS: rdData = mstatusView & S_ST_VIEW;
      SEL_MIE:     rdData = mieQ;
      SEL_SIE:     rdData = mieQ & midelegQ;
      SEL_MIDELEG: rdData = midelegQ;
      SEL_MEDELEG: rdData = medelegQ;
      SEL_MTVEC:   rdData = mtvecQ;
      SEL_STVEC:   rdData = stvecQ;
      SEL_MIP:     rdData = mipView;
      SEL_SIP:     rdData = mipView & midelegQ;
      SEL_HART:    rdData = XLEN'(HART_ID);
      default:     rdData = '0;
    endcase
  end

endmodule

// File: rtl/trap_csr_bank.sv
module trap_csr_bank
  import trap_csr_pkg::*;
#(
  parameter int          XLEN    = 32,
  parameter logic [31:0] HART_ID = 32'h0
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic [11:0]     addr,
  input  logic [XLEN-1:0] wrData,
  input  logic            irqTimerIn,
  input  logic            irqExtIn,
  input  logic            irqSupExtIn,
  output logic [XLEN-1:0] rdData
);

  csrCtl_t ctl;

  trap_csr_ctrl ctrl_i (
    .wrEn (wrEn),
    .addr (addr),
    .ctl  (ctl)
  );

  trap_csr_dp #(.XLEN(XLEN), .HART_ID(HART_ID)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .wrData      (wrData),
    .irqTimerIn  (irqTimerIn),
    .irqExtIn    (irqExtIn),
    .irqSupExtIn (irqSupExtIn),
    .rdData      (rdData)
  );

endmodule

// File: rtl/trap_csr_chk.sv
module trap_csr_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            wrEn,
  input logic [11:0]     addr,
  input logic [XLEN-1:0] wrData,
  input logic [XLEN-1:0] rdData,
  input logic            irqTimerIn,
  input logic [XLEN-1:0] mtvecQ,
  input logic [XLEN-1:0] midelegQ,
  input logic [XLEN-1:0] medelegQ,
  input logic [XLEN-1:0] mipView
);

  // R8
  mtvec_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 12'h305 && wrData[1]) |=> $stable(mtvecQ));

  // R7
  medeleg_hole_chk: assert property (@(posedge clk) disable iff (!rstN)
    (medelegQ[10] == 1'b0) && (medelegQ[14] == 1'b0));

  // R5
  mideleg_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (midelegQ & ~XLEN'(32'h222)) == '0);

  // R10
  timer_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (mipView[7] == $past(irqTimerIn)));

  // R6
  sie_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addr == 12'h104) |-> ((rdData & ~midelegQ) == '0));

  // R3
  summary_dirty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addr == 12'h300) |->
      (rdData[XLEN-1] == ((rdData[14:13] == 2'b11) || (rdData[16:15] == 2'b11))));

endmodule

bind trap_csr_bank trap_csr_chk #(.XLEN(XLEN)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .addr       (addr),
  .wrData     (wrData),
  .rdData     (rdData),
  .irqTimerIn (irqTimerIn),
  .mtvecQ     (dp_i.mtvecQ),
  .midelegQ   (dp_i.midelegQ),
  .medelegQ   (dp_i.medelegQ),
  .mipView    (dp_i.mipView)
);

// File: tb/trap_csr_bank_tb_top.sv
module trap_csr_bank_tb_top;

  localparam logic [31:0] HART = 32'h0000_0007;
  localparam logic [31:0] MM   = 32'h007E_79AA;
  localparam logic [31:0] SM   = 32'h800D_E133;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wrData = '0;
  logic        irqTimerIn = 1'b0, irqExtIn = 1'b0, irqSupExtIn = 1'b0;
  logic [31:0] rdData;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  // bench model
  logic [31:0] mst = '0, mieM = '0, midM = '0, medM = '0, mtv = '0, stv = '0, mipSw = '0;
  logic        hT = 1'b0, hE = 1'b0, hS = 1'b0;

  logic [11:0] addrList [15] = '{12'h300, 12'h100, 12'h304, 12'h104, 12'h303, 12'h302,
                                 12'h305, 12'h105, 12'h344, 12'h144, 12'hF11, 12'hF12,
                                 12'hF13, 12'hF14, 12'h7C0};

  always #10 clk = ~clk;

  trap_csr_bank #(.XLEN(32), .HART_ID(HART)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .irqTimerIn(irqTimerIn), .irqExtIn(irqExtIn), .irqSupExtIn(irqSupExtIn),
    .rdData(rdData)
  );

  function automatic logic [31:0] statusView();
    return mst | ((mst[14:13] == 2'b11 || mst[16:15] == 2'b11) ? 32'h8000_0000 : 32'h0);
  endfunction

  function automatic logic [31:0] pendView();
    return (mipSw & 32'h22) | (32'(hT) << 7) | (32'(hS) << 9) | (32'(hE) << 11);
  endfunction

  function automatic logic [31:0] expRead(logic [11:0] a);
    case (a)
      12'h300: return statusView();
      12'h100: return statusView() & SM;
      12'h304: return mieM;
      12'h104: return mieM & midM;
      12'h303: return midM;
      12'h302: return medM;
      12'h305: return mtv;
      12'h105: return stv;
      12'h344: return pendView();
      12'h144: return pendView() & midM;
      12'hF14: return HART;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string reqOf(logic [11:0] a);
    case (a)
      12'h300: return "R2";
      12'h100: return "R4";
      12'h304, 12'h303: return "R5";
      12'h104: return "R6";
      12'h302: return "R7";
      12'h305, 12'h105: return "R8";
      12'h344, 12'h144: return "R9";
      default: return "R1";
    endcase
  endfunction

  task automatic applyWrite(logic [11:0] a, logic [31:0] d);
    logic [31:0] nv;
    case (a)
      12'h300: mst = (mst & ~MM) | (d & MM);
      12'h100: begin nv = (mst & ~SM) | (d & SM); mst = (mst & ~MM) | (nv & MM); end
      12'h304: mieM = (mieM & ~32'hAAA) | (d & 32'hAAA);
      12'h104: begin nv = (mieM & ~midM) | (d & midM); mieM = (mieM & ~32'hAAA) | (nv & 32'hAAA); end
      12'h303: midM = d & 32'h222;
      12'h302: medM = d & 32'hB3FF;
      12'h305: if (d[1:0] < 2) mtv = d;
      12'h105: if (d[1:0] < 2) stv = d;
      12'h344: mipSw = (mipSw & ~32'h22) | (d & 32'h22);
      12'h144: begin nv = 32'h2 & midM; mipSw = (mipSw & ~nv) | (d & nv); end
      default: ;
    endcase
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic readCheck(logic [11:0] a, string req);
    @(negedge clk);
    wrEn = 1'b0; addr = a;
    #2 check(req, rdData, expRead(a));
  endtask

  // R11: during the write cycle the old value is visible; model updates after the edge
  task automatic writeOp(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    #2 check("R11", rdData, expRead(a));
    @(posedge clk);
    #1 wrEn = 1'b0;
    applyWrite(a, d);
  endtask

  task automatic setHw(logic t, logic e, logic s);
    @(negedge clk);
    irqTimerIn = t; irqExtIn = e; irqSupExtIn = s;
    @(posedge clk);
    #1 hT = t; hE = e; hS = s;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL R11 watchdog actual=timeout expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] seedDummy;
    seedDummy = $urandom(32'h5EED_1234);
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset values and identity registers
    foreach (addrList[i]) readCheck(addrList[i], "R1");

    // R2: only writable status bits change
    writeOp(12'h300, 32'hFFFF_FFFF);
    readCheck(12'h300, "R2");
    // R3: FS = 3 sets the summary bit; FS = 1 clears it
    writeOp(12'h300, 32'h0000_6000);
    readCheck(12'h300, "R3");
    writeOp(12'h300, 32'h0000_2000);
    readCheck(12'h300, "R3");
    // R4: supervisor status window
    writeOp(12'h100, 32'hFFFF_FFFF);
    readCheck(12'h100, "R4");
    readCheck(12'h300, "R4");

    // R5: enable and delegation masks
    writeOp(12'h304, 32'hFFFF_FFFF);
    readCheck(12'h304, "R5");
    writeOp(12'h303, 32'hFFFF_FFFF);
    readCheck(12'h303, "R5");
    // R6: supervisor enable writes touch only delegated bits
    writeOp(12'h303, 32'h0000_0020);
    writeOp(12'h104, 32'h0000_0000);
    readCheck(12'h304, "R6");
    readCheck(12'h104, "R6");

    // R7: exception delegation holes at causes 10 and 14
    writeOp(12'h302, 32'hFFFF_FFFF);
    readCheck(12'h302, "R7");

    // R8: direct and vectored kept, reserved modes dropped
    writeOp(12'h305, 32'h0000_1001);
    readCheck(12'h305, "R8");
    writeOp(12'h305, 32'h0000_2002);
    readCheck(12'h305, "R8");
    writeOp(12'h105, 32'h0000_3003);
    readCheck(12'h105, "R8");
    writeOp(12'h105, 32'h0000_4000);
    readCheck(12'h105, "R8");

    // R9: pending writes
    writeOp(12'h344, 32'hFFFF_FFFF);
    readCheck(12'h344, "R9");
    writeOp(12'h303, 32'h0000_0000);
    writeOp(12'h144, 32'h0000_0000);
    readCheck(12'h344, "R9");
    readCheck(12'h144, "R9");
    writeOp(12'h303, 32'h0000_0222);
    writeOp(12'h144, 32'h0000_0000);
    readCheck(12'h344, "R9");
    readCheck(12'h144, "R9");

    // R10: hardware lines drive their pending bits and override software
    setHw(1'b1, 1'b1, 1'b1);
    readCheck(12'h344, "R10");
    writeOp(12'h344, 32'h0000_0000);
    readCheck(12'h344, "R10");
    setHw(1'b0, 1'b1, 1'b0);
    readCheck(12'h344, "R10");
    readCheck(12'h144, "R10");

    // random mix
    for (int it = 0; it < 600; it++) begin
      logic [11:0] a;
      logic [31:0] d;
      a = addrList[$urandom_range(0, 14)];
      d = $urandom;
      if ($urandom_range(0, 3) != 0) writeOp(a, d);
      readCheck(a, reqOf(a));
      if ((it % 16) == 0)
        setHw(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule